// File: doc/BRIEF.md
# Third-Order One-Bit Sigma-Delta Noise Shaper

This block turns oversampled signed PCM samples into a single-bit stream for an audio DAC. Each accepted sample produces one output bit. The output runs at the same oversampled rate as the input, which is 128 times the audio sample rate. The loop is third order. It pushes quantization noise out of the audio band so that a later reconstruction stage can recover the signal with a high signal-to-noise ratio.

The loop is a chain of three integrators. It has a single feedback point at the input and weighted feed-forward taps into a one-bit quantizer. The quantizer node is `s1 - s1/4 + s2/4 + s3/32`, where s1, s2 and s3 are the three integrator states and each division is an arithmetic right shift. The first integrator adds `input - feedback`. The second integrator adds the old s1, and the third adds the old s2. The feedback is `+2^(IN_W-1)` for an output bit of 1 and `-2^(IN_W-1)` for a 0.

Every integrator is wider than the input by guard bits, and its adder saturates instead of wrapping. The block is driven only by the input strobe, so it behaves the same whether the base rate is 8 kHz or 100 kHz, and whether or not the clock is doubled for double-speed use.

Top module: `noise_shaper3`

## Requirements
- R1: For each cycle with `smp_valid` high, `bit_valid` is high in the next cycle with the new `bit_out`; `bit_valid` is low in the cycle after any cycle with `smp_valid` low.
- R2: While `smp_valid` is low, `smp_data` has no effect: the integrator states and `bit_out` hold, and the next accepted sample continues the same sequence.
- R3: Reset clears all three integrators to zero. From reset, with an all-zero input, the first eight bits are 1,0,0,1,0,1,1,0. A reset applied mid-stream restarts this sequence.
- R4: The output bit is 1 when the quantizer node is zero or positive, and 0 when it is negative. A 1 feeds back plus full scale, and a 0 feeds back minus full scale. Full scale is `2^(IN_W-1)`.
- R5: With a zero input, the ones count over 4096 accepted samples is 2048 with a tolerance of ±40 (1 %).
- R6: With a constant input u where |u| ≤ FS/2, the ones count over 4096 accepted samples is 2048·(1+u/FS) with a tolerance of ±40.
- R7: Each integrator saturates at its signed limits. It never wraps, and it stays at a limit while the increment pushes further that way.
- R8: The bit sequence depends only on the sequence of accepted samples, and not on the number of idle cycles between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deasserts through a two-flop synchronizer |
| smp_valid | input | 1 | Strobe at 128× the audio rate; high accepts `smp_data` |
| smp_data | input | IN_W | Signed two's-complement oversampled sample |
| bit_out | output | 1 | One-bit modulator output |
| bit_valid | output | 1 | High for one cycle when `bit_out` carries a new bit |

## Verification
The bench builds the block with a 16-bit input and six guard bits. Full scale is then 32768, so the quantizer taps are exact shifts of full scale. This makes the first eight bits after reset easy to compute by hand. The narrow guard range lets the integrators reach their limits in short runs. The density windows test DC tracking at zero, at plus one quarter and at minus one half of full scale. Repeating one sample pattern with and without idle gaps checks that the output does not depend on the clock-to-sample ratio.

// File: rtl/ns3_pkg.sv
package ns3_pkg;
  localparam int unsigned NS_ORDER = 3;
  // Feed-forward tap shifts into the quantizer node
  localparam int unsigned TAP1_SH = 2;  // s1 - s1/4 = 0.75*s1
  localparam int unsigned TAP2_SH = 2;  // 0.25*s2
  localparam int unsigned TAP3_SH = 5;  // 0.03125*s3

  typedef enum logic {
    QBIT_NEG = 1'b0,
    QBIT_POS = 1'b1
  } qbit_e;
endpackage

// File: rtl/ns3_integ.sv
module ns3_integ #(
  parameter int unsigned SW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [SW-1:0] inc,
  output logic signed [SW-1:0] st
);
  localparam logic signed [SW-1:0] ST_MAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] ST_MIN = {1'b1, {(SW-1){1'b0}}};

  logic signed [SW:0]   sum_w;
  logic signed [SW-1:0] st_nxt;
  logic                 ovf;

  always_comb begin
    sum_w = {st[SW-1], st} + {inc[SW-1], inc};
    ovf   = (sum_w[SW] != sum_w[SW-1]);
    if (!en) begin
      st_nxt = st;
    end else if (ovf) begin
      st_nxt = sum_w[SW] ? ST_MIN : ST_MAX;
    end else begin
      st_nxt = sum_w[SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st <= st_nxt;
    end
  end

  // R7
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_MAX && !inc[SW-1]) |=> (st == ST_MAX));
  // R7
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == ST_MIN && inc[SW-1]) |=> (st == ST_MIN));
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st));
endmodule

// File: rtl/ns3_quant.sv
module ns3_quant
  import ns3_pkg::*;
#(
  parameter int unsigned SW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [SW-1:0] s1,
  input  logic signed [SW-1:0] s2,
  input  logic signed [SW-1:0] s3,
  output qbit_e                qbit
);
  localparam int unsigned QW = SW + 3;

  logic signed [QW-1:0] e1, e2, e3, node;

  always_comb begin
    e1   = QW'(s1);
    e2   = QW'(s2);
    e3   = QW'(s3);
    node = e1 - (e1 >>> TAP1_SH) + (e2 >>> TAP2_SH) + (e3 >>> TAP3_SH);
    qbit = node[QW-1] ? QBIT_NEG : QBIT_POS;
  end

  // R4
  nonneg_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1[SW-1] && !s2[SW-1] && !s3[SW-1]) |-> (qbit == QBIT_POS));
endmodule

// File: rtl/noise_shaper3.sv
module noise_shaper3
  import ns3_pkg::*;
#(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned GUARD = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [IN_W-1:0] smp_data,
  output logic            bit_out,
  output logic            bit_valid
);
  localparam int unsigned SW = IN_W + GUARD;
  localparam logic signed [SW-1:0] FS_POS = SW'(1) <<< (IN_W - 1);
  localparam logic signed [SW-1:0] FS_NEG = -FS_POS;

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q = rst_sync[1];

  logic signed [SW-1:0] st  [NS_ORDER];
  logic signed [SW-1:0] inc [NS_ORDER];
  logic signed [SW-1:0] u_ext, fb;
  qbit_e                qbit;

  always_comb begin
    u_ext  = SW'($signed(smp_data));
    fb     = (qbit == QBIT_POS) ? FS_POS : FS_NEG;
    inc[0] = u_ext - fb;
    for (int k = 1; k < NS_ORDER; k++) begin
      inc[k] = st[k-1];
    end
  end

  for (genvar g = 0; g < NS_ORDER; g++) begin : g_stage
    ns3_integ #(.SW(SW)) i_integ (
      .clk  (clk),
      .rst_n(rst_q),
      .en   (smp_valid),
      .inc  (inc[g]),
      .st   (st[g])
    );
  end

  ns3_quant #(.SW(SW)) i_quant (
    .clk  (clk),
    .rst_n(rst_q),
    .s1   (st[0]),
    .s2   (st[1]),
    .s3   (st[2]),
    .qbit (qbit)
  );

  logic bit_out_nxt, bit_valid_nxt;

  always_comb begin
    bit_valid_nxt = smp_valid;
    bit_out_nxt   = smp_valid ? (qbit == QBIT_POS) : bit_out;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_out   <= bit_out_nxt;
      bit_valid <= bit_valid_nxt;
    end
  end

  // R1
  strobe_out_chk: assert property (@(posedge clk) disable iff (!rst_q)
    smp_valid |=> bit_valid);
  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !smp_valid |=> !bit_valid);
  // R2
  idle_bit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !smp_valid |=> $stable(bit_out));
endmodule

// File: tb/test_noise_shaper3.sv
`timescale 1ns/1ps
module test_noise_shaper3;
  localparam int IN_W  = 16;
  localparam int GUARD = 6;
  localparam int FS    = 1 << (IN_W - 1);
  localparam int NWIN  = 4096;
  localparam int TOL   = 40;

  // {sample, expected bit} from reset, zero input (R3, R4)
  localparam int NVEC = 8;
  localparam logic [IN_W:0] VEC [NVEC] = '{
    {16'sd0, 1'b1}, {16'sd0, 1'b0}, {16'sd0, 1'b0}, {16'sd0, 1'b1},
    {16'sd0, 1'b0}, {16'sd0, 1'b1}, {16'sd0, 1'b1}, {16'sd0, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            smp_valid;
  logic [IN_W-1:0] smp_data;
  logic            bit_out;
  logic            bit_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  noise_shaper3 #(.IN_W(IN_W), .GUARD(GUARD)) i_noise_shaper3 (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .smp_data (smp_data),
    .bit_out  (bit_out),
    .bit_valid(bit_valid)
  );

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One accepted sample followed by 'gap' idle cycles carrying junk data
  task automatic tick(input logic [IN_W-1:0] u, input int gap, output logic b);
    smp_valid = 1'b1;
    smp_data  = u;
    @(negedge clk);
    b = bit_out;
    if (bit_valid !== 1'b1) check("R1 bit_valid after strobe", int'(bit_valid), 1);
    smp_valid = 1'b0;
    smp_data  = 16'h5A5A ^ u;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      if (bit_valid !== 1'b0) check("R1 bit_valid idle", int'(bit_valid), 0);
      if (bit_out !== b) check("R2 bit_out hold", int'(bit_out), int'(b));
    end
  endtask

  task automatic density(input int u, input string req);
    logic b;
    int ones = 0;
    for (int i = 0; i < 512; i++) tick(IN_W'(u), 0, b);
    for (int i = 0; i < NWIN; i++) begin
      tick(IN_W'(u), 0, b);
      ones += int'(b);
    end
    begin
      int expv = (NWIN / 2) + (NWIN / 2) * u / FS;
      check_range(req, ones, expv - TOL, expv + TOL);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic b;
    logic seq_a [64];
    int   mism;
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    do_reset();

    // R3 reset state: no bit presented
    check("R3 reset bit_valid", int'(bit_valid), 0);

    // R3 / R4: vector table from reset, idle gaps with junk data (R2)
    for (int k = 0; k < NVEC; k++) begin
      tick(VEC[k][IN_W:1], k % 3, b);
      check($sformatf("R3 R4 vector %0d", k), int'(b), int'(VEC[k][0]));
    end

    // R1: explicit idle check
    @(negedge clk);
    check("R1 idle bit_valid low", int'(bit_valid), 0);

    // R5 / R6: DC density windows
    density(0, "R5 zero density");
    density(FS / 4, "R6 quarter density");
    density(-(FS / 2), "R6 minus half density");

    // R7: overload, then reset restarts the sequence (R3)
    for (int i = 0; i < 3000; i++) tick(IN_W'(FS - 1), 0, b);
    for (int i = 0; i < 3000; i++) tick(IN_W'(-FS), 0, b);
    do_reset();
    for (int k = 0; k < 4; k++) begin
      tick('0, 0, b);
      check($sformatf("R3 R7 restart %0d", k), int'(b), int'(VEC[k][0]));
    end

    // R8: same sample pattern, dense vs. gapped strobes
    do_reset();
    for (int k = 0; k < 64; k++) tick(IN_W'((k % 5) * (FS / 8) - FS / 4), 0, seq_a[k]);
    do_reset();
    mism = 0;
    for (int k = 0; k < 64; k++) begin
      tick(IN_W'((k % 5) * (FS / 8) - FS / 4), 2, b);
      if (b !== seq_a[k]) mism++;
    end
    check("R8 spacing independence mismatches", mism, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule